// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Counter

This block keeps time of day and calendar date as packed BCD fields: seconds, minutes, hours (24-hour), day of week, date, month, year and century. A free-running internal set of fields advances on every counting pulse of a one-per-second tick. It carries through minutes, hours, days and months, follows each month's length and inserts 29 February in leap years. Software reaches the fields through a byte-wide register port with a 5-bit address, a write strobe and a combinational read path.

A transfer-enable control bit decides what software sees. While the bit is 1, reads return the live count and writes go straight into it. Clearing the bit freezes a user-visible shadow copy of the count, so a multi-byte read is coherent, while the internal set keeps counting. Fields written during the freeze are marked. When the bit is set again, only the marked fields are loaded into the internal set. The other fields keep the time that elapsed during the freeze.

Counting stops while bit 7 of the month register is 1 or while the `osc_hold` input is high. Two spare control bits share the month byte and are stored as written.

Top module: `rtc_dual_calendar`

## Requirements
- R1: After reset the fields read seconds 00h, minutes 00h, hours 00h, day of week 01h, date 01h, month register (05h) 01h, year 00h, century 20h, and the control register (0Fh) reads 80h (transfer enable = 1).
- R2: Addresses 00h to 07h hold seconds, minutes, hours, day of week, date, month, year and century. Each counting tick adds one BCD second. Seconds roll from 59h to 00h and add a minute, minutes roll from 59h to 00h and add an hour, and hours roll from 23h to 00h and advance both the date and the day of week.
- R3: The date rolls to 01h after 31h in months 01h, 03h, 05h, 07h, 08h, 10h and 12h, and after 30h in months 04h, 06h, 09h and 11h, advancing the month. Month 12h rolls to 01h and adds one to the year.
- R4: February (02h) ends at 29h when the year value is divisible by 4 (including 00h) and at 28h otherwise.
- R5: When the year rolls from 99h to 00h, the century advances. The century rolls from 39h to 00h.
- R6: The day of week advances at each midnight and wraps from 07h to 01h, independently of the date.
- R7: Bits outside each field's range read 0 and cannot be written: seconds and minutes keep bits 6:0, hours and date keep bits 5:0, day of week keeps bits 2:0, month keeps bits 4:0, year keeps all 8 bits and century keeps bits 5:0. Every address other than 00h-07h and 0Fh reads 00h.
- R8: Month register bit 7 set to 1, or `osc_hold` high, stops all counting. Bits 7:5 of 05h read back as written, above the month value.
- R9: Writing 0 to 0Fh bit 7 freezes the visible fields at the count held just before the write, while the internal count keeps advancing on ticks. Fields written during the freeze read back the written value.
- R10: Writing 1 to 0Fh bit 7 after a freeze loads only the fields written during the freeze into the internal count. The fields not written show the internal count, including the ticks that came during the freeze.
- R11: Only a write to 0Fh changes the transfer-enable bit, and bits 6:0 of 0Fh read 0.
- R12: While transfer enable is 1, a write to a time field reads back at once and the count continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| osc_hold | input | 1 | High stops counting |
| bus_addr | input | ADDR_W (5) | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for bus_addr, combinational |

## Verification
A wrong internal carry or month-length decision appears at the ports on the first tick that crosses the boundary concerned. It shows as a wrong date, month, year or century byte, so the bench places the count one second before each rollover and reads every field after the tick. A wrong snapshot or a missing write mark stays hidden during the freeze and only appears when transfer enable returns. The bench therefore reads both the frozen values and the values after resume, and compares the fields that were written against those that were not.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

   localparam int NFIELD = 8;
   localparam int BCD_W  = 8;

   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DOW  = 3;
   localparam int F_DATE = 4;
   localparam int F_MON  = 5;
   localparam int F_YEAR = 6;
   localparam int F_CENT = 7;

   typedef logic [BCD_W-1:0] bcd_t;

   // Writable bits of each field; all others read 0.
   function automatic bcd_t field_mask(int idx);
      case (idx)
         F_SEC, F_MIN:    return 8'h7F;
         F_HOUR, F_DATE:  return 8'h3F;
         F_DOW:           return 8'h07;
         F_MON:           return 8'h1F;
         F_YEAR:          return 8'hFF;
         default:         return 8'h3F;
      endcase
   endfunction

   // Value a field takes after it wraps.
   function automatic bcd_t field_lo(int idx);
      case (idx)
         F_DOW, F_DATE, F_MON: return 8'h01;
         default:              return 8'h00;
      endcase
   endfunction

   // Last value before wrap (date is supplied by the month-length logic).
   function automatic bcd_t field_hi(int idx);
      case (idx)
         F_SEC, F_MIN: return 8'h59;
         F_HOUR:       return 8'h23;
         F_DOW:        return 8'h07;
         F_DATE:       return 8'h31;
         F_MON:        return 8'h12;
         F_YEAR:       return 8'h99;
         default:      return 8'h39;
      endcase
   endfunction

   function automatic bcd_t field_rst(int idx);
      case (idx)
         F_DOW, F_DATE, F_MON: return 8'h01;
         F_CENT:               return 8'h20;
         default:              return 8'h00;
      endcase
   endfunction

   // Which field's carry advances a given field.
   function automatic int carry_src(int idx);
      case (idx)
         F_MIN:          return F_SEC;
         F_HOUR:         return F_MIN;
         F_DOW, F_DATE:  return F_HOUR;
         F_MON:          return F_DATE;
         F_YEAR:         return F_MON;
         F_CENT:         return F_YEAR;
         default:        return F_SEC;
      endcase
   endfunction

   function automatic bcd_t bcd_inc(bcd_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   function automatic logic year_is_leap(bcd_t y);
      if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
   endfunction

endpackage

// File: rtl/rtc_month_len.sv
`timescale 1ns/1ps
module rtc_month_len
   import rtc_cal_pkg::*;
(
   input  bcd_t month,
   input  bcd_t year,
   output bcd_t last_date
);

   logic leap;

   assign leap = year_is_leap(year);

   always_comb begin
      case (month)
         8'h02:                      last_date = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
         default:                    last_date = 8'h31;
      endcase
   end

endmodule

// File: rtl/rtc_field_step.sv
`timescale 1ns/1ps
module rtc_field_step
   import rtc_cal_pkg::*;
#(
   parameter bcd_t LO   = 8'h00,
   parameter bcd_t MASK = 8'hFF
)(
   input  bcd_t cur,
   input  bcd_t hi,
   input  logic en,
   output bcd_t nxt,
   output logic carry
);

   logic at_top;

   // A value at or beyond the last legal one wraps on the next step.
   assign at_top = (cur >= hi);
   assign carry  = en && at_top;

   always_comb begin
      if (!en)         nxt = cur;
      else if (at_top) nxt = LO;
      else             nxt = bcd_inc(cur) & MASK;
   end

endmodule

// File: rtl/rtc_time_core.sv
`timescale 1ns/1ps
module rtc_time_core
   import rtc_cal_pkg::*;
#(
   parameter int NF = NFIELD
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [NF-1:0]     ovr_mask,
   input  bcd_t [NF-1:0]     ovr_val,
   output bcd_t [NF-1:0]     cur_q
);

   if (NF != NFIELD) begin : g_bad_nf
      $error("rtc_time_core: NF must equal the calendar field count");
   end

   bcd_t          base [NF];
   bcd_t [NF-1:0] nxt_p;
   logic          en_w [NF];
   logic          cy_w [NF];
   bcd_t          last_day;

   rtc_month_len u_mlen (
      .month     (base[F_MON]),
      .year      (base[F_YEAR]),
      .last_date (last_day)
   );

   for (genvar i = 0; i < NF; i++) begin : g_field
      bcd_t hi_v;

      assign base[i] = ovr_mask[i] ? (ovr_val[i] & field_mask(i)) : cur_q[i];

      if (i == 0) begin : g_first
         assign en_w[i] = step;
      end else begin : g_chain
         assign en_w[i] = cy_w[carry_src(i)];
      end

      if (i == F_DATE) begin : g_var_hi
         assign hi_v = last_day;
      end else begin : g_fix_hi
         assign hi_v = field_hi(i);
      end

      rtc_field_step #(
         .LO   (field_lo(i)),
         .MASK (field_mask(i))
      ) u_step (
         .cur   (base[i]),
         .hi    (hi_v),
         .en    (en_w[i]),
         .nxt   (nxt_p[i]),
         .carry (cy_w[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NF; i++) cur_q[i] <= field_rst(i);
      end else begin
         cur_q <= nxt_p;
      end
   end

   // R2: a counting tick at 59 seconds lands on 00
   assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && base[F_SEC] == 8'h59) |=> (cur_q[F_SEC] == 8'h00));

   // R6: day of week wraps from 7 to 1
   assert_dow_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w[F_DOW] && base[F_DOW] == 8'h07) |=> (cur_q[F_DOW] == 8'h01));

   // R5: a century carry leaves century at 00
   assert_cent_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cy_w[F_CENT] |=> (cur_q[F_CENT] == 8'h00));

   // R8: no step and no override keeps the whole count
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && ovr_mask == '0) |=> $stable(cur_q));

endmodule

// File: rtl/rtc_shadow_bank.sv
`timescale 1ns/1ps
module rtc_shadow_bank
   import rtc_cal_pkg::*;
#(
   parameter int NF = NFIELD
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              live,
   input  logic              capture,
   input  logic              resume,
   input  bcd_t [NF-1:0]     src,
   input  logic [NF-1:0]     wr_sel,
   input  bcd_t              wr_val,
   output bcd_t [NF-1:0]     ext_q,
   output logic [NF-1:0]     dirty_q
);

   if (NF != NFIELD) begin : g_bad_nf
      $error("rtc_shadow_bank: NF must equal the calendar field count");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NF; i++) ext_q[i] <= field_rst(i);
         dirty_q <= '0;
      end else if (capture) begin
         ext_q   <= src;
         dirty_q <= '0;
      end else if (resume) begin
         dirty_q <= '0;
      end else if (!live) begin
         for (int i = 0; i < NF; i++) begin
            if (wr_sel[i]) begin
               ext_q[i]   <= wr_val & field_mask(i);
               dirty_q[i] <= 1'b1;
            end
         end
      end
   end

   // R9: snapshot equals the live count of the halt cycle
   assert_snapshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (ext_q == $past(src)));

   // R9: frozen copy only moves on a user write
   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !capture && !resume && wr_sel == '0) |=> $stable(ext_q));

   // R10: a write during the freeze marks its field
   assert_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !capture && !resume && wr_sel != '0)
         |=> ((dirty_q & $past(wr_sel)) == $past(wr_sel)));

   // R10: marks are gone after the resume
   assert_resume_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> (dirty_q == '0));

endmodule

// File: rtl/rtc_dual_calendar.sv
`timescale 1ns/1ps
module rtc_dual_calendar
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 15
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              osc_hold,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int FIDX_W = $clog2(NFIELD);

   if (DATA_W != BCD_W) begin : g_bad_data
      $error("rtc_dual_calendar: DATA_W must match the BCD field width");
   end
   if (ADDR_W <= FIDX_W) begin : g_bad_addr
      $error("rtc_dual_calendar: address too narrow for the field block");
   end
   if (CTRL_ADDR < NFIELD || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_ctrl
      $error("rtc_dual_calendar: control address out of range");
   end

   logic              te_q;
   logic              stop_q;
   logic [1:0]        aux_q;
   logic              time_wr;
   logic              ctrl_wr;
   logic              mon_wr;
   logic              go_halt;
   logic              go_live;
   logic              step;
   logic [FIDX_W-1:0] fidx;
   logic [NFIELD-1:0] ovr_mask;
   bcd_t [NFIELD-1:0] ovr_val;
   logic [NFIELD-1:0] shadow_sel;
   bcd_t [NFIELD-1:0] cur;
   bcd_t [NFIELD-1:0] ext;
   logic [NFIELD-1:0] dirty;
   bcd_t [NFIELD-1:0] view;

   assign fidx    = bus_addr[FIDX_W-1:0];
   assign time_wr = bus_wr && (bus_addr < ADDR_W'(NFIELD));
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign mon_wr  = bus_wr && (bus_addr == ADDR_W'(F_MON));
   assign go_halt = ctrl_wr && te_q && !bus_wdata[DATA_W-1];
   assign go_live = ctrl_wr && !te_q && bus_wdata[DATA_W-1];
   assign step    = tick_1hz && !osc_hold && !stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         te_q   <= 1'b1;
         stop_q <= 1'b0;
         aux_q  <= '0;
      end else begin
         if (ctrl_wr) te_q <= bus_wdata[DATA_W-1];
         if (mon_wr) begin
            stop_q <= bus_wdata[DATA_W-1];
            aux_q  <= bus_wdata[DATA_W-2:DATA_W-3];
         end
      end
   end

   for (genvar i = 0; i < NFIELD; i++) begin : g_route
      logic hit;
      assign hit           = time_wr && (fidx == FIDX_W'(i));
      assign ovr_mask[i]   = te_q ? hit : (go_live && dirty[i]);
      assign ovr_val[i]    = te_q ? bus_wdata : ext[i];
      assign shadow_sel[i] = hit && !te_q;
      assign view[i]       = te_q ? cur[i] : ext[i];
   end

   rtc_time_core #(.NF(NFIELD)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .ovr_mask (ovr_mask),
      .ovr_val  (ovr_val),
      .cur_q    (cur)
   );

   rtc_shadow_bank #(.NF(NFIELD)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .live    (te_q),
      .capture (go_halt),
      .resume  (go_live),
      .src     (cur),
      .wr_sel  (shadow_sel),
      .wr_val  (bus_wdata),
      .ext_q   (ext),
      .dirty_q (dirty)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(F_MON))
         bus_rdata = {stop_q, aux_q, view[F_MON][4:0]};
      else if (bus_addr < ADDR_W'(NFIELD))
         bus_rdata = view[fidx];
      else if (bus_addr == ADDR_W'(CTRL_ADDR))
         bus_rdata = {te_q, {(DATA_W-1){1'b0}}};
   end

   // R11: transfer enable moves only on a control write
   assert_te_write_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(te_q));

   // R8: a tick blocked by the stop bit leaves the live count alone
   assert_stop_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !time_wr && !go_live) |=> $stable(cur));

endmodule

// File: tb/tb_rtc_dual_calendar.sv
`timescale 1ns/1ps
module tb_rtc_dual_calendar;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic       hold;
   logic       wr;
   logic [4:0] addr;
   logic [7:0] wdata;
   logic [7:0] rdata;
   int         checks = 0;
   int         failures = 0;

   always #4 clk = ~clk;

   rtc_dual_calendar dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_1hz  (tick),
      .osc_hold  (hold),
      .bus_addr  (addr),
      .bus_wr    (wr),
      .bus_wdata (wdata),
      .bus_rdata (rdata)
   );

   function automatic logic [7:0] bcd(int n);
      return 8'(((n / 10) * 16) + (n % 10));
   endfunction

   function automatic int month_days(int m, int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [4:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic expect_reg(string tag, logic [4:0] a, logic [7:0] exp);
      @(negedge clk);
      addr = a;
      #1;
      check(tag, rdata, exp);
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic set_time(int h, int mi, int s, int dw, int dt, int mo, int yr, logic [7:0] cen);
      bus_write(5'h00, bcd(s));
      bus_write(5'h01, bcd(mi));
      bus_write(5'h02, bcd(h));
      bus_write(5'h03, bcd(dw));
      bus_write(5'h04, bcd(dt));
      bus_write(5'h05, bcd(mo));
      bus_write(5'h06, bcd(yr));
      bus_write(5'h07, cen);
   endtask

   initial begin
      #1600000;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; hold = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_reg("R1 sec", 5'h00, 8'h00);
      expect_reg("R1 min", 5'h01, 8'h00);
      expect_reg("R1 hour", 5'h02, 8'h00);
      expect_reg("R1 dow", 5'h03, 8'h01);
      expect_reg("R1 date", 5'h04, 8'h01);
      expect_reg("R1 month", 5'h05, 8'h01);
      expect_reg("R1 year", 5'h06, 8'h00);
      expect_reg("R1 century", 5'h07, 8'h20);
      expect_reg("R1 ctrl", 5'h0F, 8'h80);

      // R7 every other address reads zero, also after a write attempt
      bus_write(5'h08, 8'hAA);
      bus_write(5'h1F, 8'h55);
      for (int a = 8; a < 32; a++) begin
         if (a != 15) expect_reg("R7 unused", 5'(a), 8'h00);
      end

      // R2 / R12: count through more than an hour from zero
      set_time(0, 0, 0, 1, 1, 1, 24, 8'h20);
      expect_reg("R12 readback date", 5'h04, 8'h01);
      expect_reg("R12 readback year", 5'h06, 8'h24);
      for (int n = 1; n <= 3700; n++) begin
         pulse_tick();
         expect_reg("R2 sec", 5'h00, bcd(n % 60));
         expect_reg("R2 min", 5'h01, bcd((n / 60) % 60));
         expect_reg("R2 hour", 5'h02, bcd(n / 3600));
      end

      // R2 hour carry, R6 day of week at midnight
      set_time(22, 59, 59, 3, 10, 3, 24, 8'h20);
      pulse_tick();
      expect_reg("R2 hour carry", 5'h02, 8'h23);
      expect_reg("R2 min wrap", 5'h01, 8'h00);
      expect_reg("R6 dow unchanged", 5'h03, 8'h03);
      for (int d = 1; d <= 7; d++) begin
         set_time(23, 59, 59, d, 10, 3, 24, 8'h20);
         pulse_tick();
         expect_reg("R2 midnight hour", 5'h02, 8'h00);
         expect_reg("R2 midnight date", 5'h04, 8'h11);
         expect_reg("R6 dow", 5'h03, bcd((d % 7) + 1));
      end

      // R3 / R4 month-end sweep over eight years
      for (int y = 0; y < 8; y++) begin
         for (int m = 1; m <= 12; m++) begin
            for (int d = 27; d <= month_days(m, y); d++) begin
               int ed, em, ey;
               set_time(23, 59, 59, 2, d, m, y, 8'h20);
               pulse_tick();
               ed = (d == month_days(m, y)) ? 1 : d + 1;
               em = (ed == 1) ? ((m == 12) ? 1 : m + 1) : m;
               ey = (ed == 1 && m == 12) ? y + 1 : y;
               expect_reg("R3 date", 5'h04, bcd(ed));
               expect_reg("R3 month", 5'h05, bcd(em));
               expect_reg("R3 year", 5'h06, bcd(ey));
            end
         end
      end

      // R4 February 28 across every year value
      for (int y = 0; y < 100; y++) begin
         set_time(23, 59, 59, 1, 28, 2, y, 8'h20);
         pulse_tick();
         expect_reg("R4 feb date", 5'h04, (y % 4 == 0) ? 8'h29 : 8'h01);
         expect_reg("R4 feb month", 5'h05, (y % 4 == 0) ? 8'h02 : 8'h03);
      end

      // R5 year and century rollover
      set_time(23, 59, 59, 1, 31, 12, 99, 8'h19);
      pulse_tick();
      expect_reg("R5 year wrap", 5'h06, 8'h00);
      expect_reg("R5 century", 5'h07, 8'h20);
      expect_reg("R5 month wrap", 5'h05, 8'h01);
      set_time(23, 59, 59, 1, 31, 12, 99, 8'h39);
      pulse_tick();
      expect_reg("R5 century wrap", 5'h07, 8'h00);

      // R7 masking of unused bits on write
      bus_write(5'h00, 8'hFF);
      expect_reg("R7 sec mask", 5'h00, 8'h7F);
      bus_write(5'h02, 8'hFF);
      expect_reg("R7 hour mask", 5'h02, 8'h3F);
      bus_write(5'h03, 8'hFF);
      expect_reg("R7 dow mask", 5'h03, 8'h07);
      bus_write(5'h07, 8'hFF);
      expect_reg("R7 century mask", 5'h07, 8'h3F);

      // R8 stop bit and hold input
      set_time(8, 0, 10, 1, 5, 6, 30, 8'h20);
      bus_write(5'h05, 8'hE6);
      expect_reg("R8 ctrl bits", 5'h05, 8'hE6);
      pulse_tick();
      expect_reg("R8 stopped sec", 5'h00, 8'h10);
      bus_write(5'h05, 8'h06);
      hold = 1'b1;
      pulse_tick();
      expect_reg("R8 held sec", 5'h00, 8'h10);
      hold = 1'b0;
      pulse_tick();
      expect_reg("R8 running sec", 5'h00, 8'h11);

      // R9 / R10 freeze with one field written
      set_time(12, 30, 15, 4, 9, 7, 31, 8'h20);
      bus_write(5'h0F, 8'h00);
      expect_reg("R9 ctrl halted", 5'h0F, 8'h00);
      repeat (5) pulse_tick();
      expect_reg("R9 frozen sec", 5'h00, 8'h15);
      expect_reg("R9 frozen min", 5'h01, 8'h30);
      bus_write(5'h01, 8'h45);
      expect_reg("R9 written min", 5'h01, 8'h45);
      bus_write(5'h0F, 8'h80);
      expect_reg("R10 unwritten sec", 5'h00, 8'h20);
      expect_reg("R10 written min", 5'h01, 8'h45);
      expect_reg("R10 unwritten hour", 5'h02, 8'h12);
      pulse_tick();
      expect_reg("R10 continues", 5'h00, 8'h21);

      // R9 / R10 freeze with nothing written
      bus_write(5'h0F, 8'h00);
      repeat (3) pulse_tick();
      expect_reg("R9 frozen again", 5'h00, 8'h21);
      bus_write(5'h0F, 8'h80);
      expect_reg("R10 caught up", 5'h00, 8'h24);
      expect_reg("R10 min kept", 5'h01, 8'h45);

      // R11 transfer-enable bit only follows control writes
      bus_write(5'h0F, 8'h7F);
      expect_reg("R11 low bits", 5'h0F, 8'h00);
      repeat (2) pulse_tick();
      bus_write(5'h00, 8'h00);
      expect_reg("R11 still halted", 5'h0F, 8'h00);
      bus_write(5'h0F, 8'hFF);
      expect_reg("R11 enabled", 5'h0F, 8'h80);
      expect_reg("R11 sec after resume", 5'h00, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule